// File: doc/BRIEF.md
# Multi-Port Atomic Memory Unit

A small word-addressed shared store that several requesters, such as processor cores, reach through their own ports. Every request is an indivisible read-modify-write. The operation may be a plain load, a plain store, an exchange, a fetch-and-increment, a test-and-set or a compare-and-swap. The previous content of the addressed word is always returned to the requester.

A round-robin arbiter admits at most one request per clock. In the admitted cycle the old word is read and the new word is written, so all accesses to every location fall into one global order. This makes the block a sound base for spin locks. The lock word holds 0 when free and 1 when taken. A requester exchanges in 1 and owns the lock only if it gets 0 back. It releases the lock by storing 0.

Each port has a valid/ready request handshake. The response is a one-cycle valid pulse carrying the old word.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every word holds 0 and no response valid is asserted.
- R2: Opcode 0 (load) returns the addressed word and leaves it unchanged. Opcodes 6 and 7 behave exactly like opcode 0.
- R3: Opcode 1 (store) writes the write operand and returns the previous word.
- R4: Opcode 2 (exchange) writes the write operand and returns the previous word. A later load observes the new value.
- R5: Opcode 3 (fetch-and-increment) writes the old word plus one, wrapping to 0 at the word width, and returns the old word.
- R6: Opcode 4 (test-and-set) writes 1 and returns the old word.
- R7: Opcode 5 (compare-and-swap) writes the write operand only when the old word equals the compare operand. It always returns the old word.
- R8: At most one port sees ready in any cycle, and only a port that presents valid.
- R9: After a grant to port p, the next grant goes to the first valid port found searching upward from p+1, wrapping around. No valid port waits N_PORTS cycles or more.
- R10: A granted port sees its response valid for exactly the cycle after the grant, carrying the word as it was before the granted operation.
- R11: When all ports exchange 1 into the same free lock word in the same cycle, exactly one of them receives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_ready | output | N_PORTS | Request granted this cycle |
| req_op | input | 3*N_PORTS | Opcode per port |
| req_addr | input | ADDR_W*N_PORTS | Word address per port |
| req_wdata | input | DATA_W*N_PORTS | Write / new-value operand per port |
| req_cmp | input | DATA_W*N_PORTS | Compare operand per port |
| rsp_valid | output | N_PORTS | One-cycle response pulse per port |
| rsp_data | output | DATA_W*N_PORTS | Previous word returned per port |

## Verification
The assertions rely on one assumption about the inputs: a port that raises valid keeps its request unchanged until it sees ready. The starvation bound and the response-timing check are both only meaningful under that assumption. The stimulus therefore changes a port's request only half a cycle away from the edge, and drops valid only after the edge at which ready was seen. In the lock race, all four ports hold identical exchange requests until each one is served in turn.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
   typedef enum logic [2:0] {
      OPC_LOAD  = 3'd0,
      OPC_STORE = 3'd1,
      OPC_XCHG  = 3'd2,
      OPC_FINC  = 3'd3,
      OPC_TSET  = 3'd4,
      OPC_CAS   = 3'd5
   } opcode_e;
   localparam int OPC_W = 3;
endpackage

// File: rtl/rr_grant.sv
module rr_grant #(
   parameter int N_PORTS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PORTS-1:0] valid,
   output logic [N_PORTS-1:0] gnt,
   output logic [$clog2(N_PORTS)-1:0] gnt_idx
);
   localparam int IDX_W = $clog2(N_PORTS);
   localparam int CNT_W = $clog2(N_PORTS) + 1;

   generate
      if (N_PORTS < 2) begin : g_bad_ports
         $error("rr_grant needs at least two ports");
      end
   endgenerate

   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      for (int k = N_PORTS - 1; k >= 0; k--) begin
         int idx;
         idx = (int'(ptr_q) + k) % N_PORTS;
         if (valid[idx]) begin
            gnt     = '0;
            gnt[idx] = 1'b1;
            gnt_idx = IDX_W'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (|gnt) begin
         if (int'(gnt_idx) == N_PORTS - 1) ptr_q <= '0;
         else                              ptr_q <= gnt_idx + 1'b1;
      end
   end

   // Per-port wait counters for the starvation bound
   logic [CNT_W-1:0] wait_q [N_PORTS];
   for (genvar i = 0; i < N_PORTS; i++) begin : g_wait
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   wait_q[i] <= '0;
         else if (valid[i] && !gnt[i]) wait_q[i] <= wait_q[i] + 1'b1;
         else                          wait_q[i] <= '0;
      end
      assert_no_starve_R9: assert property (@(posedge clk) disable iff (!rst_n)
         int'(wait_q[i]) < N_PORTS);
   end

   assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~valid) == '0);
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
   import atomic_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] compare,
   output logic              wr_en,
   output logic [DATA_W-1:0] new_word
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rmw_alu needs a word of at least two bits");
      end
   endgenerate

   always_comb begin
      wr_en    = 1'b0;
      new_word = old_word;
      case (op)
         OPC_STORE, OPC_XCHG: begin
            wr_en    = 1'b1;
            new_word = operand;
         end
         OPC_FINC: begin
            wr_en    = 1'b1;
            new_word = old_word + 1'b1;
         end
         OPC_TSET: begin
            wr_en    = 1'b1;
            new_word = DATA_W'(1);
         end
         OPC_CAS: begin
            wr_en    = (old_word == compare);
            new_word = operand;
         end
         default: begin
            wr_en    = 1'b0;
            new_word = old_word;
         end
      endcase
   end
endmodule

// File: rtl/word_store.sv
module word_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
         $error("word_store address width out of range");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];

   assign rd_data = mem_q[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[addr] <= wr_data;
      end
   end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_pkg::*;
#(
   parameter int N_PORTS = 4,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_PORTS-1:0]         req_valid,
   output logic [N_PORTS-1:0]         req_ready,
   input  logic [OPC_W*N_PORTS-1:0]   req_op,
   input  logic [ADDR_W*N_PORTS-1:0]  req_addr,
   input  logic [DATA_W*N_PORTS-1:0]  req_wdata,
   input  logic [DATA_W*N_PORTS-1:0]  req_cmp,
   output logic [N_PORTS-1:0]         rsp_valid,
   output logic [DATA_W*N_PORTS-1:0]  rsp_data
);
   localparam int IDX_W = $clog2(N_PORTS);

   logic [N_PORTS-1:0] gnt;
   logic [IDX_W-1:0]   gnt_idx;
   logic [OPC_W-1:0]   sel_op;
   logic [ADDR_W-1:0]  sel_addr;
   logic [DATA_W-1:0]  sel_wdata, sel_cmp, old_word, new_word;
   logic               alu_wr, mem_wr;

   rr_grant #(.N_PORTS(N_PORTS)) u_arb (
      .clk(clk), .rst_n(rst_n), .valid(req_valid),
      .gnt(gnt), .gnt_idx(gnt_idx)
   );

   assign req_ready = gnt;
   assign sel_op    = req_op   [int'(gnt_idx)*OPC_W  +: OPC_W];
   assign sel_addr  = req_addr [int'(gnt_idx)*ADDR_W +: ADDR_W];
   assign sel_wdata = req_wdata[int'(gnt_idx)*DATA_W +: DATA_W];
   assign sel_cmp   = req_cmp  [int'(gnt_idx)*DATA_W +: DATA_W];

   word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(sel_addr), .rd_data(old_word),
      .wr_en(mem_wr), .wr_data(new_word)
   );

   rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op(sel_op), .old_word(old_word), .operand(sel_wdata),
      .compare(sel_cmp), .wr_en(alu_wr), .new_word(new_word)
   );

   assign mem_wr = alu_wr && (|gnt);

   logic [N_PORTS-1:0] rsp_valid_q;
   logic [DATA_W-1:0]  rsp_data_q [N_PORTS];

   for (genvar i = 0; i < N_PORTS; i++) begin : g_rsp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid_q[i] <= 1'b0;
            rsp_data_q[i]  <= '0;
         end else begin
            rsp_valid_q[i] <= gnt[i];
            if (gnt[i]) rsp_data_q[i] <= old_word;
         end
      end
      assign rsp_data[i*DATA_W +: DATA_W] = rsp_data_q[i];

      assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid[i] && !req_ready[i] |=> req_valid[i]);
      assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         req_ready[i] |=> rsp_valid[i]);
   end

   assign rsp_valid = rsp_valid_q;

   assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid));
   assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_ready) |=> !(|rsp_valid));
endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;
   localparam int NP = 4;
   localparam int DW = 8;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NP-1:0]    req_valid = '0;
   logic [NP-1:0]    req_ready;
   logic [3*NP-1:0]  req_op    = '0;
   logic [AW*NP-1:0] req_addr  = '0;
   logic [DW*NP-1:0] req_wdata = '0;
   logic [DW*NP-1:0] req_cmp   = '0;
   logic [NP-1:0]    rsp_valid;
   logic [DW*NP-1:0] rsp_data;

   atomic_rmw_unit #(.N_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_cmp(req_cmp), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_req(input int p, input int op, input int a, input int wd, input int cm);
      req_op[p*3 +: 3]     = 3'(op);
      req_addr[p*AW +: AW] = AW'(a);
      req_wdata[p*DW +: DW] = DW'(wd);
      req_cmp[p*DW +: DW]   = DW'(cm);
      req_valid[p] = 1'b1;
   endtask

   // Single-port transaction; returns the old word from the response
   task automatic do_op(input int p, input int op, input int a, input int wd,
                        input int cm, output int old);
      @(negedge clk);
      set_req(p, op, a, wd, cm);
      #1;
      while (!req_ready[p]) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 req_valid[p] = 1'b0;
      @(negedge clk);
      check("R10 rsp_valid", int'(rsp_valid[p]), 1);
      old = int'(rsp_data[p*DW +: DW]);
      @(negedge clk);
      check("R10 single pulse", int'(rsp_valid[p]), 0);
   endtask

   // All ports exchange 1 into word a at once; returns number of zeros seen
   task automatic lock_race(input int a, output int zeros);
      int order [NP];
      int prev;
      zeros = 0;
      prev = -1;
      @(negedge clk);
      for (int p = 0; p < NP; p++) set_req(p, 2, a, 1, 0);
      for (int c = 0; c < NP; c++) begin
         int g;
         #1;
         if (prev >= 0) begin
            check("R10 race rsp", int'(rsp_valid[prev]), 1);
            if (rsp_data[prev*DW +: DW] == '0) zeros++;
         end
         check("R8 one ready", $countones(req_ready), 1);
         g = 0;
         for (int p = 0; p < NP; p++) if (req_ready[p]) g = p;
         order[c] = g;
         if (c > 0) check("R9 rr order", g, (order[c-1] + 1) % NP);
         @(posedge clk);
         #1 req_valid[g] = 1'b0;
         prev = g;
         @(negedge clk);
      end
      #1;
      check("R10 race rsp", int'(rsp_valid[prev]), 1);
      if (rsp_data[prev*DW +: DW] == '0) zeros++;
   endtask

   initial begin
      int old, z;
      repeat (3) @(negedge clk);
      check("R1 rsp_valid reset", int'(rsp_valid), 0);
      check("R8 no ready idle", int'(req_ready), 0);
      rst_n = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
         do_op(a % NP, 0, a, 0, 0, old);
         check("R1 word zero", old, 0);
      end
      // R3 store, R2 load: every port, every address
      for (int p = 0; p < NP; p++) begin
         for (int a = 0; a < (1 << AW); a++) begin
            int v;
            v = (p * 37 + a * 11 + 5) % 256;
            do_op(p, 1, a, v, 0, old);
            do_op((p + 1) % NP, 0, a, 0, 0, old);
            check("R3 store/load", old, v);
            do_op((p + 2) % NP, 0, a, 0, 0, old);
            check("R2 load no change", old, v);
         end
      end
      // R2 unused opcodes act as load
      do_op(0, 1, 2, 77, 0, old);
      do_op(1, 6, 2, 9, 77, old);
      check("R2 op6 returns", old, 77);
      do_op(2, 7, 2, 9, 77, old);
      check("R2 op7 returns", old, 77);
      do_op(3, 0, 2, 0, 0, old);
      check("R2 op6/7 no write", old, 77);
      // R4 exchange
      do_op(0, 2, 3, 200, 0, old);
      do_op(1, 2, 3, 15, 0, old);
      check("R4 xchg old", old, 200);
      do_op(2, 0, 3, 0, 0, old);
      check("R4 xchg new", old, 15);
      // R5 fetch-and-increment with wrap
      do_op(0, 1, 4, 254, 0, old);
      do_op(1, 3, 4, 0, 0, old);
      check("R5 finc old", old, 254);
      do_op(2, 3, 4, 0, 0, old);
      check("R5 finc old", old, 255);
      do_op(3, 0, 4, 0, 0, old);
      check("R5 finc wrap", old, 0);
      // R6 test-and-set
      do_op(0, 1, 5, 0, 0, old);
      do_op(1, 4, 5, 0, 0, old);
      check("R6 tset free", old, 0);
      do_op(2, 4, 5, 0, 0, old);
      check("R6 tset held", old, 1);
      do_op(0, 1, 5, 90, 0, old);
      do_op(3, 4, 5, 0, 0, old);
      check("R6 tset old", old, 90);
      do_op(0, 0, 5, 0, 0, old);
      check("R6 tset writes 1", old, 1);
      // R7 compare-and-swap sweep
      for (int ov = 0; ov < 4; ov++) begin
         for (int cv = 0; cv < 4; cv++) begin
            do_op(0, 1, 6, ov, 0, old);
            do_op((ov + cv) % NP, 5, 6, 64, cv, old);
            check("R7 cas returns old", old, ov);
            do_op(1, 0, 6, 0, 0, old);
            check("R7 cas result", old, (ov == cv) ? 64 : ov);
         end
      end
      // R11 lock race, release, race again
      do_op(0, 1, 0, 0, 0, old);
      lock_race(0, z);
      check("R11 one winner", z, 1);
      do_op(1, 0, 0, 0, 0, old);
      check("R11 lock held", old, 1);
      do_op(2, 1, 0, 0, 0, old);
      lock_race(0, z);
      check("R11 one winner again", z, 1);
      lock_race(0, z);
      check("R11 no winner held", z, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule